// File: doc/BRIEF.md
# Staged-Entry Translation Buffer

This block is a small, fully associative address translation buffer that is filled through control-register style writes rather than by a hardware walker. Software first writes a page-table-entry image into a holding register. It can write the current address-space number (ASN) at any time. A later tag write then commits one new entry. The entry takes its translation fields from the held image, its address-space number from the ASN register and its virtual page number from the tag write.

A combinational lookup port matches a virtual page number against every valid entry. It returns a hit flag, the physical page number, the read-enable and write-enable masks and the two fault-on-access bits. A separate flush port removes translations in one of three ways: every entry, only the process-private entries (those whose global-match bit is clear), or the single entry whose page and address-space number both match.

A two-state machine tracks whether the holding register has been loaded since reset. `ST_IDLE` is the reset state. Any staging write moves it along the transition `ST_IDLE -> ST_STAGED`. `ST_STAGED` then holds itself until reset. A tag write is accepted only in `ST_STAGED`.

Top module: `staged_xlate_buf`

## Requirements
- R1: After reset no entry is valid, so every lookup misses and all lookup outputs read zero. The holding register and the ASN register read zero, `ins_err` is low and the state is `ST_IDLE`.
- R2: A write with `wr_sel`=00 loads the holding register, which shows on `stage_rd` from the next cycle. Only the defined fields are kept: physical page number at bits 58:32, read enables at 11:8, write enables at 15:12, fault-on-read at bit 1, fault-on-write at bit 2, global-match at bit 4 and page-size hint at bits 6:5. Every other bit reads zero.
- R3: A lookup hits when a valid entry has the same virtual page and either its ASN equals the ASN register or its global-match bit is set. The result is combinational. When several entries hit, the lowest slot wins. On a miss all lookup outputs are zero.
- R4: A write with `wr_sel`=01 loads the ASN register from `wr_data[6:0]`. A write with `wr_sel`=10 (tag write) in `ST_STAGED` with a zero hint field installs an entry at the next clock edge. The entry's page is `wr_data[VPN_W-1:0]`, its ASN is the ASN register and its fields come from the holding register. `wr_sel`=11 does nothing.
- R5: A tag write whose held hint field (bits 6:5) is nonzero installs nothing. `ins_err` is then high for exactly the one following cycle.
- R6: A tag write in `ST_IDLE` installs nothing and raises `ins_err` for one cycle. The first staging write moves the state to `ST_STAGED`, where it stays until reset.
- R7: If an installed entry has the same page and ASN as a valid entry, it overwrites that entry in place. Otherwise it takes the slot at the round-robin pointer, which then advances modulo the entry count. The ninth distinct install after a full flush therefore evicts the first.
- R8: A `flush_op`=01 invalidates every entry at the next edge.
- R9: A `flush_op`=10 invalidates only the entries whose global-match bit is clear. The global entries stay usable.
- R10: A `flush_op`=11 invalidates only the entry whose page equals `flush_vpn` and whose ASN equals the ASN register.
- R11: When a flush and a tag write arrive in the same cycle, the flush is applied and the install is dropped without raising `ins_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 00 stage, 01 ASN, 10 tag/commit, 11 none |
| wr_data | input | 64 | Write data |
| flush_op | input | 2 | 00 none, 01 all, 10 process-private, 11 single |
| flush_vpn | input | VPN_W | Page for single flush |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 27 | Physical page number |
| lk_rd_en | output | 4 | Read-enable mask |
| lk_wr_en | output | 4 | Write-enable mask |
| lk_fault_rd | output | 1 | Fault-on-read bit |
| lk_fault_wr | output | 1 | Fault-on-write bit |
| stage_rd | output | 64 | Holding register readback |
| ins_err | output | 1 | One-cycle pulse after a rejected install |

## Verification
Most internal corruption in this block shows up at the lookup port within one cycle. A wrong valid bit, slot choice or stored ASN turns into a wrong hit or wrong fields on the next probe of the affected page. A fault in the round-robin pointer or in the in-place overwrite stays hidden until a later install evicts the wrong page, so the bench follows long install sequences and probes pages that are being evicted. An error in the state machine or the hint check shows as a missing or extra `ins_err` pulse in the cycle right after the tag write.

// File: rtl/sxb_pkg.sv
`timescale 1ns/1ps
package sxb_pkg;
    localparam int DATA_W  = 64;
    localparam int PPN_W   = 27;
    localparam int PERM_W  = 4;
    localparam int ASN_W   = 7;
    localparam int PPN_LSB = 32;
    localparam int RE_LSB  = 8;
    localparam int WE_LSB  = 12;
    localparam int FOR_BIT = 1;
    localparam int FOW_BIT = 2;
    localparam int GLB_BIT = 4;
    localparam int GH_LSB  = 5;
    localparam int GH_W    = 2;

    localparam logic [DATA_W-1:0] STAGE_MASK =
        (((64'd1 << PPN_W) - 64'd1) << PPN_LSB) |
        (64'hF << RE_LSB) | (64'hF << WE_LSB) |
        (64'd1 << FOR_BIT) | (64'd1 << FOW_BIT) | (64'd1 << GLB_BIT) |
        (64'd3 << GH_LSB);

    typedef enum logic [1:0] {
        WR_STAGE = 2'b00,
        WR_ASN   = 2'b01,
        WR_TAG   = 2'b10,
        WR_NONE  = 2'b11
    } wr_sel_e;

    typedef enum logic [1:0] {
        FL_NONE = 2'b00,
        FL_ALL  = 2'b01,
        FL_PROC = 2'b10,
        FL_ONE  = 2'b11
    } flush_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_STAGED = 1'b1
    } stage_st_e;

    typedef struct packed {
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] re;
        logic [PERM_W-1:0] we;
        logic              f_rd;
        logic              f_wr;
        logic              glb;
    } pte_t;

    function automatic pte_t unpack_pte(input logic [DATA_W-1:0] v);
        pte_t p;
        p.ppn  = v[PPN_LSB +: PPN_W];
        p.re   = v[RE_LSB +: PERM_W];
        p.we   = v[WE_LSB +: PERM_W];
        p.f_rd = v[FOR_BIT];
        p.f_wr = v[FOW_BIT];
        p.glb  = v[GLB_BIT];
        return p;
    endfunction
endpackage

// File: rtl/sxb_slot.sv
`timescale 1ns/1ps
module sxb_slot
    import sxb_pkg::*;
#(
    parameter int VPN_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [VPN_W-1:0] ld_vpn,
    input  pte_t             ld_pte,
    input  logic [1:0]       fl_op,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [ASN_W-1:0] cur_asn,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             valid_o,
    output logic             lk_hit_o,
    output logic             dup_o,
    output pte_t             pte_o
);
    logic             vld_q;
    logic [VPN_W-1:0] vpn_q;
    logic [ASN_W-1:0] asn_q;
    pte_t             pte_q;
    logic             kill;

    always_comb begin
        unique case (flush_e'(fl_op))
            FL_ALL:  kill = 1'b1;
            FL_PROC: kill = !pte_q.glb;
            FL_ONE:  kill = (vpn_q == fl_vpn) && (asn_q == cur_asn);
            default: kill = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            vpn_q <= '0;
            asn_q <= '0;
            pte_q <= '0;
        end else if (flush_e'(fl_op) != FL_NONE) begin
            if (kill) vld_q <= 1'b0;
        end else if (ld_en) begin
            vld_q <= 1'b1;
            vpn_q <= ld_vpn;
            asn_q <= cur_asn;
            pte_q <= ld_pte;
        end
    end

    assign valid_o  = vld_q;
    assign pte_o    = pte_q;
    assign lk_hit_o = vld_q && (vpn_q == lk_vpn) && ((asn_q == cur_asn) || pte_q.glb);
    assign dup_o    = vld_q && (vpn_q == ld_vpn) && (asn_q == cur_asn);

    // R11
    flush_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_op != 2'b00) |=> !(vld_q && !$past(vld_q)));
endmodule

// File: rtl/sxb_victim.sv
`timescale 1ns/1ps
module sxb_victim #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         alloc,
    input  logic [N-1:0] dup_vec,
    output logic [N-1:0] sel
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;
    localparam logic [PW-1:0] LAST = PW'(N - 1);

    logic [PW-1:0] ptr_q;
    logic [N-1:0]  first_dup;
    logic          any_dup;

    assign any_dup = |dup_vec;

    always_comb begin
        first_dup = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (dup_vec[i]) begin
                first_dup    = '0;
                first_dup[i] = 1'b1;
            end
        end
    end

    always_comb begin
        if (any_dup) begin
            sel = first_dup;
        end else begin
            sel        = '0;
            sel[ptr_q] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (alloc && !any_dup) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    // R7
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q == $past(ptr_q)) ||
        (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));

    // R7
    sel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> ($countones(sel) == 1));
endmodule

// File: rtl/sxb_pick.sv
`timescale 1ns/1ps
module sxb_pick
    import sxb_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] hit_vec,
    input  pte_t         pte_arr [N],
    output logic         hit,
    output pte_t         pte
);
    always_comb begin
        hit = 1'b0;
        pte = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit = 1'b1;
                pte = pte_arr[i];
            end
        end
    end
endmodule

// File: rtl/staged_xlate_buf.sv
`timescale 1ns/1ps
module staged_xlate_buf
    import sxb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [63:0]      wr_data,
    input  logic [1:0]       flush_op,
    input  logic [VPN_W-1:0] flush_vpn,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [26:0]      lk_ppn,
    output logic [3:0]       lk_rd_en,
    output logic [3:0]       lk_wr_en,
    output logic             lk_fault_rd,
    output logic             lk_fault_wr,
    output logic [63:0]      stage_rd,
    output logic             ins_err
);
    stage_st_e        st_q, st_d;
    logic [63:0]      stage_q;
    logic [ASN_W-1:0] asn_q;
    logic             ins_err_q;

    logic             stage_wr, asn_wr, tag_wr, fl_act;
    logic             gh_bad, commit_ok, reject;
    pte_t             stage_pte;

    logic [ENTRIES-1:0] vld_vec, hit_vec, dup_vec, glb_vec, sel_vec;
    pte_t               pte_arr [ENTRIES];
    pte_t               lk_pte;

    assign stage_wr  = wr_en && (wr_sel_e'(wr_sel) == WR_STAGE);
    assign asn_wr    = wr_en && (wr_sel_e'(wr_sel) == WR_ASN);
    assign tag_wr    = wr_en && (wr_sel_e'(wr_sel) == WR_TAG);
    assign fl_act    = (flush_e'(flush_op) != FL_NONE);
    assign gh_bad    = (stage_q[GH_LSB +: GH_W] != '0);
    assign stage_pte = unpack_pte(stage_q);
    assign commit_ok = tag_wr && !fl_act && (st_q == ST_STAGED) && !gh_bad;
    assign reject    = tag_wr && !fl_act && !((st_q == ST_STAGED) && !gh_bad);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (stage_wr) st_d = ST_STAGED;
            ST_STAGED: st_d = ST_STAGED;
            default:   st_d = ST_IDLE;
        endcase
    end

    // outputs and control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q   <= '0;
            asn_q     <= '0;
            ins_err_q <= 1'b0;
        end else begin
            if (stage_wr) stage_q <= wr_data & STAGE_MASK;
            if (asn_wr)   asn_q   <= wr_data[ASN_W-1:0];
            ins_err_q <= reject;
        end
    end

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
            sxb_slot #(.VPN_W(VPN_W)) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .ld_en    (commit_ok && sel_vec[g]),
                .ld_vpn   (wr_data[VPN_W-1:0]),
                .ld_pte   (stage_pte),
                .fl_op    (flush_op),
                .fl_vpn   (flush_vpn),
                .cur_asn  (asn_q),
                .lk_vpn   (lk_vpn),
                .valid_o  (vld_vec[g]),
                .lk_hit_o (hit_vec[g]),
                .dup_o    (dup_vec[g]),
                .pte_o    (pte_arr[g])
            );
            assign glb_vec[g] = pte_arr[g].glb;
        end
    endgenerate

    sxb_victim #(.N(ENTRIES)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .alloc   (commit_ok),
        .dup_vec (dup_vec),
        .sel     (sel_vec)
    );

    sxb_pick #(.N(ENTRIES)) u_pick (
        .hit_vec (hit_vec),
        .pte_arr (pte_arr),
        .hit     (lk_hit),
        .pte     (lk_pte)
    );

    assign lk_ppn      = lk_pte.ppn;
    assign lk_rd_en    = lk_pte.re;
    assign lk_wr_en    = lk_pte.we;
    assign lk_fault_rd = lk_pte.f_rd;
    assign lk_fault_wr = lk_pte.f_wr;
    assign stage_rd    = stage_q;
    assign ins_err     = ins_err_q;

    // R8
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_op == 2'b01) |=> (vld_vec == '0));

    // R9
    flush_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_op == 2'b10) |=> (((vld_vec & ~glb_vec) == '0) &&
                                 (($past(vld_vec & glb_vec) & ~vld_vec) == '0)));

    // R5
    gh_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_wr && !fl_act && gh_bad) |=> (ins_err && (vld_vec == $past(vld_vec))));

    // R6
    idle_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_wr && (st_q == ST_IDLE)) |=> (vld_vec == $past(vld_vec)));

    // R4
    one_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vld_vec) <= $past($countones(vld_vec)) + 1);
endmodule

// File: tb/tb_staged_xlate_buf.sv
`timescale 1ns/1ps
module tb_staged_xlate_buf;
    localparam int N  = 8;
    localparam int VW = 30;
    localparam logic [63:0] MASK = 64'h07FF_FFFF_0000_FF76;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'b11;
    logic [63:0]   wr_data = '0;
    logic [1:0]    flush_op = 2'b00;
    logic [VW-1:0] flush_vpn = '0;
    logic [VW-1:0] lk_vpn = '0;
    logic          lk_hit, lk_fault_rd, lk_fault_wr, ins_err;
    logic [26:0]   lk_ppn;
    logic [3:0]    lk_rd_en, lk_wr_en;
    logic [63:0]   stage_rd;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    staged_xlate_buf #(.ENTRIES(N), .VPN_W(VW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .flush_op(flush_op), .flush_vpn(flush_vpn), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en),
        .lk_fault_rd(lk_fault_rd), .lk_fault_wr(lk_fault_wr),
        .stage_rd(stage_rd), .ins_err(ins_err)
    );

    // reference model built from the requirements
    logic          m_v   [N];
    logic [VW-1:0] m_vpn [N];
    logic [6:0]    m_asn [N];
    logic [63:0]   m_raw [N];
    int            m_ptr;
    logic          m_staged;
    logic [63:0]   m_stage;
    logic [6:0]    m_cur;
    logic          m_err;

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 1'b0; m_vpn[i] = '0; m_asn[i] = '0; m_raw[i] = '0;
        end
        m_ptr = 0; m_staged = 1'b0; m_stage = '0; m_cur = '0; m_err = 1'b0;
    endtask

    task automatic model_apply(input logic we, input logic [1:0] sel,
                               input logic [63:0] d, input logic [1:0] fo,
                               input logic [VW-1:0] fv);
        m_err = 1'b0;
        if (fo != 2'b00) begin
            for (int i = 0; i < N; i++) begin
                if (fo == 2'b01) m_v[i] = 1'b0;
                else if (fo == 2'b10 && !m_raw[i][4]) m_v[i] = 1'b0;
                else if (fo == 2'b11 && m_vpn[i] == fv && m_asn[i] == m_cur) m_v[i] = 1'b0;
            end
        end
        if (we) begin
            if (sel == 2'b00) begin
                m_stage  = d & MASK;
                m_staged = 1'b1;
            end else if (sel == 2'b01) begin
                m_cur = d[6:0];
            end else if (sel == 2'b10 && fo == 2'b00) begin
                if (!m_staged || m_stage[6:5] != 2'b00) begin
                    m_err = 1'b1;
                end else begin
                    int slot = -1;
                    for (int i = N - 1; i >= 0; i--)
                        if (m_v[i] && m_vpn[i] == d[VW-1:0] && m_asn[i] == m_cur) slot = i;
                    if (slot < 0) begin
                        slot  = m_ptr;
                        m_ptr = (m_ptr + 1) % N;
                    end
                    m_v[slot] = 1'b1; m_vpn[slot] = d[VW-1:0];
                    m_asn[slot] = m_cur; m_raw[slot] = m_stage;
                end
            end
        end
    endtask

    function automatic logic [63:0] model_lk(input logic [VW-1:0] v);
        logic [63:0] r = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_v[i] && m_vpn[i] == v && (m_asn[i] == m_cur || m_raw[i][4]))
                r = {26'd0, 1'b1, m_raw[i][58:32], m_raw[i][11:8], m_raw[i][15:12],
                     m_raw[i][1], m_raw[i][2]};
        end
        return r;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [1:0] sel, input logic [63:0] d,
                        input logic [1:0] fo, input logic [VW-1:0] fv, input string req);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = d; flush_op = fo; flush_vpn = fv;
        @(posedge clk);
        #1;
        wr_en = 1'b0; flush_op = 2'b00;
        model_apply(we, sel, d, fo, fv);
        chk(req, "ins_err", {63'd0, ins_err}, {63'd0, m_err});
        chk(req, "stage_rd", stage_rd, m_stage);
    endtask

    task automatic probe(input logic [VW-1:0] v, input string req);
        logic [63:0] act;
        lk_vpn = v;
        #0.5;
        act = {26'd0, lk_hit, lk_ppn, lk_rd_en, lk_wr_en, lk_fault_rd, lk_fault_wr};
        chk(req, "lookup", act, model_lk(v));
    endtask

    function automatic logic [63:0] mk_pte(input logic [26:0] ppn, input logic [3:0] re,
                                           input logic [3:0] we, input logic glb,
                                           input logic [1:0] gh);
        return {5'h1F, ppn, 16'hA5A5, we, re, 1'b1, gh, glb, 1'b1, 1'b1, 1'b0, 1'b1};
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240607));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "ins_err", {63'd0, ins_err}, 64'd0);
        chk("R1", "stage_rd", stage_rd, 64'd0);
        probe(30'd0, "R1");
        probe(30'd3, "R1");

        // R6 tag write before any staging is rejected
        step(1'b1, 2'b10, 64'd3, 2'b00, '0, "R6");
        probe(30'd3, "R6");
        step(1'b0, 2'b11, 64'd0, 2'b00, '0, "R5");

        // R2 staging with junk in undefined bits
        step(1'b1, 2'b00, mk_pte(27'h123, 4'h5, 4'hA, 1'b0, 2'b00), 2'b00, '0, "R2");
        // R4 install under ASN 2
        step(1'b1, 2'b01, 64'hFFFF_0002, 2'b00, '0, "R4");
        step(1'b1, 2'b10, {34'h3FF, 30'd3}, 2'b00, '0, "R4");
        probe(30'd3, "R4");
        step(1'b1, 2'b11, 64'hFFFF_FFFF, 2'b00, '0, "R4");
        probe(30'd3, "R4");
        // R3 other ASN misses, global entry hits
        step(1'b1, 2'b01, 64'd1, 2'b00, '0, "R3");
        probe(30'd3, "R3");
        step(1'b1, 2'b00, mk_pte(27'h55, 4'h3, 4'h1, 1'b1, 2'b00), 2'b00, '0, "R3");
        step(1'b1, 2'b10, 64'd4, 2'b00, '0, "R3");
        step(1'b1, 2'b01, 64'd3, 2'b00, '0, "R3");
        probe(30'd4, "R3");

        // R5 nonzero hint rejected
        step(1'b1, 2'b00, mk_pte(27'h77, 4'h1, 4'h1, 1'b0, 2'b10), 2'b00, '0, "R5");
        step(1'b1, 2'b10, 64'd6, 2'b00, '0, "R5");
        probe(30'd6, "R5");
        step(1'b0, 2'b11, 64'd0, 2'b00, '0, "R5");

        // R9 process flush keeps global entry
        step(1'b0, 2'b11, 64'd0, 2'b10, '0, "R9");
        probe(30'd4, "R9");
        step(1'b1, 2'b01, 64'd2, 2'b00, '0, "R9");
        probe(30'd3, "R9");

        // R10 single flush hits only the current ASN copy
        step(1'b1, 2'b00, mk_pte(27'h200, 4'h7, 4'h2, 1'b0, 2'b00), 2'b00, '0, "R10");
        step(1'b1, 2'b10, 64'd7, 2'b00, '0, "R10");
        step(1'b1, 2'b01, 64'd1, 2'b00, '0, "R10");
        step(1'b1, 2'b10, 64'd7, 2'b00, '0, "R10");
        step(1'b1, 2'b01, 64'd2, 2'b00, '0, "R10");
        step(1'b0, 2'b11, 64'd0, 2'b11, 30'd7, "R10");
        probe(30'd7, "R10");
        step(1'b1, 2'b01, 64'd1, 2'b00, '0, "R10");
        probe(30'd7, "R10");

        // R8 flush all, then R7 round-robin eviction and in-place overwrite
        step(1'b0, 2'b11, 64'd0, 2'b01, '0, "R8");
        probe(30'd4, "R8");
        probe(30'd7, "R8");
        step(1'b1, 2'b01, 64'd0, 2'b00, '0, "R7");
        for (int k = 0; k < 9; k++) begin
            step(1'b1, 2'b00, mk_pte(27'(k + 16), 4'h1, 4'h2, 1'b0, 2'b00), 2'b00, '0, "R7");
            step(1'b1, 2'b10, 64'(k + 10), 2'b00, '0, "R7");
        end
        probe(30'd10, "R7");
        probe(30'd11, "R7");
        probe(30'd18, "R7");
        step(1'b1, 2'b00, mk_pte(27'h4321, 4'hF, 4'h0, 1'b0, 2'b00), 2'b00, '0, "R7");
        step(1'b1, 2'b10, 64'd13, 2'b00, '0, "R7");
        probe(30'd13, "R7");
        step(1'b1, 2'b10, 64'd20, 2'b00, '0, "R7");
        probe(30'd11, "R7");
        probe(30'd12, "R7");
        probe(30'd20, "R7");

        // R11 flush and tag write together
        step(1'b1, 2'b10, 64'd21, 2'b01, '0, "R11");
        probe(30'd21, "R11");
        probe(30'd20, "R11");

        // constrained random mix
        for (int it = 0; it < 600; it++) begin
            int r = $urandom_range(0, 99);
            logic [63:0] d = {$urandom, $urandom};
            logic [1:0] fo = 2'b00;
            logic [1:0] sel;
            logic we = 1'b1;
            logic [VW-1:0] fv = VW'($urandom_range(0, 7));
            if (r < 25) begin
                sel = 2'b00;
                if ($urandom_range(0, 7) != 0) d[6:5] = 2'b00;
            end else if (r < 40) begin
                sel = 2'b01;
                d[6:0] = 7'($urandom_range(0, 3));
            end else if (r < 78) begin
                sel = 2'b10;
                d[VW-1:0] = VW'($urandom_range(0, 7));
            end else if (r < 88) begin
                we = 1'b0; sel = 2'b11;
                fo = 2'($urandom_range(1, 3));
            end else if (r < 93) begin
                sel = 2'b10;
                d[VW-1:0] = VW'($urandom_range(0, 7));
                fo = 2'($urandom_range(1, 3));
            end else begin
                we = ($urandom_range(0, 1) == 1); sel = 2'b11;
            end
            step(we, sel, d, fo, fv, "R3/R7");
            probe(VW'($urandom_range(0, 7)), "R3/R7");
        end

        finish_run();
    end
endmodule